// File: doc/BRIEF.md
# Predicated Subvector Add Sequencer

The sequencer performs an element-wise addition over a vector whose elements are short groups of scalars. A start pulse latches the operation: a group count, a group size of one to four scalars, a scalar width of 8, 16 or 32 bits, a per-group predicate mask with an optional inversion, and three base indices into an external element store: one destination and two sources. The sequencer then walks the groups in ascending order. It reads both sources and writes one wrapped sum per cycle for every scalar of an enabled group.

Predication applies to whole groups. A single mask bit turns all lanes of its group on or off. A disabled group writes nothing and takes one cycle. When the last group has been handled, a one-cycle done pulse is produced. The element store is outside the block. Its two read ports are combinational, and its write port commits on the clock edge, so a later read sees a value written earlier in the same operation.

Top module: `svseq_top`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: Scalar k of group i uses index dest_base+i*S+k for the write, src1_base+i*S+k for read port A and src2_base+i*S+k for read port B, where S is the group size. Groups are handled in ascending order, and lanes within a group in ascending order, one scalar per cycle.
- R3: Mask bit i gates group i: every lane of the group is written, or none is.
- R4: When `pred_inv` is 1, a clear mask bit enables its group and a set bit disables it.
- R5: A disabled group writes nothing and takes exactly one cycle, so a run lasts the number of enabled scalars plus the number of disabled groups.
- R6: The width code selects the scalar width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Each sum wraps modulo that width, and the bits of `wr_data` above it are zero.
- R7: `busy` is high for the whole run. `done` is a single-cycle pulse in the cycle after the last step. A group count of 0 raises `done` in the cycle after start, with no write and no busy cycle.
- R8: A start pulse that arrives while `busy` is high is ignored.
- R9: A group size of 1 gives an ordinary predicated vector add. A group size of 0 is treated as 1, and a size above 4 as 4. A group count above 64 is treated as 64.
- R10: All operation inputs are sampled only at an accepted start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| vl | input | 7 | Number of groups |
| subvl | input | 3 | Scalars per group |
| ew | input | 2 | Scalar width code |
| pred_inv | input | 1 | Invert the predicate sense |
| pred_mask | input | 64 | One enable bit per group |
| dst_base | input | 8 | Destination base index |
| src1_base | input | 8 | First source base index |
| src2_base | input | 8 | Second source base index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_a_addr | output | 8 | Read port A index |
| rd_a_data | input | 32 | Read port A data |
| rd_b_addr | output | 8 | Read port B index |
| rd_b_data | input | 32 | Read port B data |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 8 | Write index |
| wr_data | output | 32 | Write data |

## Verification
Some properties are checked on every cycle. Writes happen only while busy. Back-to-back writes step the destination index by exactly one. The done pulse lasts one cycle and coincides with the end of busy. A write at a narrow width never carries bits above that width.

Other behaviour is shown only by the bench scenarios. These cover which groups the predicate and its inversion select, the wrapped sums in the store, the exact run length with skipped groups, overlapping source and destination regions, the clamping of odd sizes, and the fact that a second start or changed inputs in mid-run have no effect.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_st_e;

    localparam logic [1:0] EW_8  = 2'd0;
    localparam logic [1:0] EW_16 = 2'd1;
endpackage

// File: rtl/svseq_pred_sel.sv
module svseq_pred_sel #(
    parameter int N  = 64,
    parameter int GW = 6
) (
    input  logic [N-1:0]  mask,
    input  logic [GW-1:0] idx,
    input  logic          inv,
    output logic          en
);
    always_comb begin
        en = mask[idx] ^ inv;
    end
endmodule

// File: rtl/svseq_addr_gen.sv
module svseq_addr_gen #(
    parameter int IW = 8,
    parameter int NP = 3
) (
    input  logic [NP-1:0][IW-1:0] bases,
    input  logic [IW-1:0]         offset,
    output logic [NP-1:0][IW-1:0] addrs
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        assign addrs[p] = bases[p] + offset;
    end
endmodule

// File: rtl/svseq_lane_add.sv
module svseq_lane_add
    import svseq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    ew,
    output logic [DW-1:0] sum
);
    logic [DW-1:0] full;

    always_comb begin
        full = a + b;
        case (ew)
            EW_8:    sum = DW'(full[7:0]);
            EW_16:   sum = DW'(full[15:0]);
            default: sum = full;
        endcase
    end
endmodule

// File: rtl/svseq_top.sv
module svseq_top
    import svseq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IW    = 8,
    parameter int MAXVL = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(MAXVL+1)-1:0]    vl,
    input  logic [2:0]                    subvl,
    input  logic [1:0]                    ew,
    input  logic                          pred_inv,
    input  logic [MAXVL-1:0]              pred_mask,
    input  logic [IW-1:0]                 dst_base,
    input  logic [IW-1:0]                 src1_base,
    input  logic [IW-1:0]                 src2_base,
    output logic                          busy,
    output logic                          done,
    output logic [IW-1:0]                 rd_a_addr,
    input  logic [DW-1:0]                 rd_a_data,
    output logic [IW-1:0]                 rd_b_addr,
    input  logic [DW-1:0]                 rd_b_data,
    output logic                          wr_en,
    output logic [IW-1:0]                 wr_addr,
    output logic [DW-1:0]                 wr_data
);
    localparam int VLW = $clog2(MAXVL + 1);
    localparam int GW  = $clog2(MAXVL);
    localparam int SVW = 3;
    localparam int LW  = 2;

    typedef struct packed {
        seq_st_e          st;
        logic [GW-1:0]    grp;
        logic [LW-1:0]    lane;
        logic [IW-1:0]    off;
        logic [VLW-1:0]   vl;
        logic [SVW-1:0]   sv;
        logic [1:0]       ew;
        logic             inv;
        logic [MAXVL-1:0] mask;
        logic [IW-1:0]    rdb;
        logic [IW-1:0]    s1b;
        logic [IW-1:0]    s2b;
        logic             done;
    } seq_t;

    seq_t d, q;

    logic                  grp_en;
    logic                  last_grp;
    logic                  last_lane;
    logic [1:0]            ew_live;
    logic [2:0][IW-1:0]    bases;
    logic [2:0][IW-1:0]    addrs;
    logic [SVW-1:0]        sv_in;
    logic [VLW-1:0]        vl_in;

    assign ew_live = q.ew;
    assign bases   = {q.s2b, q.s1b, q.rdb};

    svseq_pred_sel #(.N(MAXVL), .GW(GW)) u_pred (
        .mask (q.mask),
        .idx  (q.grp),
        .inv  (q.inv),
        .en   (grp_en)
    );

    svseq_addr_gen #(.IW(IW), .NP(3)) u_addr (
        .bases  (bases),
        .offset (q.off + IW'(q.lane)),
        .addrs  (addrs)
    );

    svseq_lane_add #(.DW(DW)) u_add (
        .a   (rd_a_data),
        .b   (rd_b_data),
        .ew  (ew_live),
        .sum (wr_data)
    );

    always_comb begin
        if (subvl == 3'd0)      sv_in = SVW'(1);
        else if (subvl > 3'd4)  sv_in = SVW'(4);
        else                    sv_in = subvl;
        vl_in     = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;
        last_grp  = (VLW'(q.grp) == q.vl - VLW'(1));
        last_lane = (q.lane == LW'(q.sv - SVW'(1)));

        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.vl   = vl_in;
                    d.sv   = sv_in;
                    d.ew   = ew;
                    d.inv  = pred_inv;
                    d.mask = pred_mask;
                    d.rdb  = dst_base;
                    d.s1b  = src1_base;
                    d.s2b  = src2_base;
                    d.grp  = '0;
                    d.lane = '0;
                    d.off  = '0;
                    if (vl_in == '0) d.done = 1'b1;
                    else             d.st   = S_RUN;
                end
            end
            default: begin
                if (grp_en && !last_lane) begin
                    d.lane = q.lane + LW'(1);
                end else begin
                    d.lane = '0;
                    d.off  = q.off + IW'(q.sv);
                    d.grp  = q.grp + GW'(1);
                    if (last_grp) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st == S_RUN);
    assign done      = q.done;
    assign wr_en     = busy && grp_en;
    assign wr_addr   = addrs[0];
    assign rd_a_addr = addrs[1];
    assign rd_b_addr = addrs[2];
endmodule

// File: rtl/svseq_chk.sv
module svseq_chk #(
    parameter int DW = 32,
    parameter int IW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [IW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [1:0]    ew_live
);
    p_write_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    p_contig_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + IW'(1)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_no_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_narrow8_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ew_live == 2'd0) |-> (wr_data[DW-1:8] == '0));

    p_narrow16_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ew_live == 2'd1) |-> (wr_data[DW-1:16] == '0));
endmodule

bind svseq_top svseq_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ew_live (ew_live)
);

// File: tb/svseq_top_test.sv
module svseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [2:0]  subvl = '0;
    logic [1:0]  ew = '0;
    logic        pred_inv = 1'b0;
    logic [63:0] pred_mask = '0;
    logic [7:0]  dst_base = '0, src1_base = '0, src2_base = '0;
    logic        busy, done, wr_en;
    logic [7:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;

    logic [31:0] mem [256];
    logic [31:0] em  [256];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    svseq_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl(subvl), .ew(ew),
        .pred_inv(pred_inv), .pred_mask(pred_mask), .dst_base(dst_base),
        .src1_base(src1_base), .src2_base(src2_base), .busy(busy), .done(done),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data), .rd_b_addr(rd_b_addr),
        .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    typedef struct packed {
        logic [6:0]  vl;
        logic [2:0]  sv;
        logic [1:0]  ew;
        logic        inv;
        logic [63:0] mask;
        logic [7:0]  rd;
        logic [7:0]  s1;
        logic [7:0]  s2;
        logic [8:0]  cyc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{7'd5,   3'd3, 2'd1, 1'b1, 64'h9,                 8'd128, 8'd0,  8'd40, 9'd11},
        '{7'd4,   3'd1, 2'd0, 1'b0, 64'hF,                 8'd100, 8'd10, 8'd20, 9'd4},
        '{7'd6,   3'd4, 2'd2, 1'b0, 64'h2D,                8'd200, 8'd0,  8'd24, 9'd18},
        '{7'd3,   3'd2, 2'd0, 1'b0, 64'h0,                 8'd50,  8'd0,  8'd6,  9'd3},
        '{7'd0,   3'd3, 2'd1, 1'b0, 64'hFF,                8'd60,  8'd0,  8'd9,  9'd0},
        '{7'd2,   3'd0, 2'd2, 1'b1, 64'h2,                 8'd70,  8'd0,  8'd5,  9'd2},
        '{7'd3,   3'd7, 2'd1, 1'b0, 64'h7,                 8'd150, 8'd0,  8'd12, 9'd12},
        '{7'd64,  3'd1, 2'd3, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 8'd128, 8'd0, 8'd64, 9'd64},
        '{7'd4,   3'd2, 2'd1, 1'b0, 64'hF,                 8'd2,   8'd0,  8'd8,  9'd8},
        '{7'd100, 3'd1, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd64, 8'd0, 8'd160, 9'd64}
    };

    function automatic logic [31:0] wmask(input logic [1:0] w, input logic [31:0] x);
        if (w == 2'd0)      return {24'd0, x[7:0]};
        else if (w == 2'd1) return {16'd0, x[15:0]};
        else                return x;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic init_mem(input int seed);
        for (int j = 0; j < 256; j++) begin
            mem[j] = 32'(j) * 32'h9E37_79B1 + 32'(seed) * 32'h7F4A_7C15 + 32'hF0F0_1234;
            em[j]  = mem[j];
        end
    endtask

    // Sequential model of the operation, built from R2 to R6 and R9
    task automatic model(input vec_t v);
        int ev, es;
        ev = (v.vl > 7'd64) ? 64 : int'(v.vl);
        es = (v.sv == 3'd0) ? 1 : (v.sv > 3'd4 ? 4 : int'(v.sv));
        for (int g = 0; g < ev; g++) begin
            if (v.mask[g] ^ v.inv) begin
                for (int k = 0; k < es; k++) begin
                    em[8'(int'(v.rd) + g*es + k)] = wmask(v.ew,
                        em[8'(int'(v.s1) + g*es + k)] + em[8'(int'(v.s2) + g*es + k)]);
                end
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx, input bit disturb);
        int cyc, bad, first;
        init_mem(idx);
        model(v);
        @(negedge clk);
        vl = v.vl; subvl = v.sv; ew = v.ew; pred_inv = v.inv; pred_mask = v.mask;
        dst_base = v.rd; src1_base = v.s1; src2_base = v.s2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == (v.vl != 0), "R7", $sformatf("vec %0d busy after start", idx),
            busy, v.vl != 0);
        if (disturb) begin
            // R10: inputs change during the run
            vl = 7'd1; subvl = 3'd1; ew = 2'd0; pred_inv = ~v.inv; pred_mask = ~v.mask;
            dst_base = 8'd240; src1_base = 8'd3; src2_base = 8'd4;
        end
        cyc = 0;
        while (!done && cyc < 2000) begin
            start = (disturb && cyc == 2);   // R8: start while busy
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == int'(v.cyc), "R5", $sformatf("vec %0d run length (R2 R9)", idx),
            cyc, v.cyc);
        @(negedge clk);
        chk(!done && !busy, "R7", $sformatf("vec %0d done width", idx), done, 0);
        bad = 0; first = -1;
        for (int j = 0; j < 256; j++)
            if (mem[j] !== em[j]) begin
                bad++;
                if (first < 0) first = j;
            end
        chk(bad == 0, "R2 R3 R4 R6", $sformatf("vec %0d store mismatches (first %0d)", idx, first),
            bad, 0);
        if (disturb)
            chk(bad == 0, disturb ? "R8 R10" : "", $sformatf("vec %0d unaffected by mid-run inputs", idx),
                bad, 0);
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "outputs during reset", {busy, done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "outputs after reset", {busy, done, wr_en}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i, 1'b0);

        // Directed: second start and changed inputs in mid-run (R8, R10)
        run_vec(VECS[0], 20, 1'b1);
        run_vec(VECS[2], 21, 1'b1);

        // Directed: SUBVL=1 ordinary add with inverted empty mask (R9, R4)
        run_vec('{7'd8, 3'd1, 2'd1, 1'b1, 64'h0, 8'd90, 8'd30, 8'd50, 9'd8}, 22, 1'b0);

        // Directed: zero group count right after another run (R7)
        run_vec(VECS[4], 23, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule